// File: doc/BRIEF.md
# EDO DRAM Page-Mode Access Controller

This block sits on the host side of an asynchronous x16 EDO DRAM and turns single-word or single-byte requests into strobe sequences. Everything runs on one clock. A request carries a row, a column, a direction flag, two byte-lane enables and write data. For each request the controller puts the row on the multiplexed address bus and drops the row strobe. It then presents the column and drops the column strobe of each selected byte lane. All minimum intervals are parameters counted in clock cycles.

When a later request targets the row that is already open, the row strobe stays low and only a new column cycle runs (page mode). A request to a different row closes the open row and reopens it. The row is also closed before the maximum row-strobe low time runs out, even under a steady stream of same-row hits or while the bus is idle. Writes are always early writes: the write strobe falls and the data drivers turn on before the column strobe falls, with the output enable held high. Reads return the sampled word with a one-cycle valid pulse.

An external refresh requester is granted the bus only while the row is closed and the row precharge interval has elapsed. No request is accepted while a refresh is requested.

Top module: `edo_page_ctrl`

## Requirements
- R1: While reset is high and after it, until the first request, every strobe (`ras_n`, `casl_n`, `cash_n`, `we_n`, `oe_n`) is high, `dq_oe`, `rd_valid` and `ref_gnt` are low.
- R2: The row strobe falls only after it has been high for at least T_RP cycles, with the row address on `dram_addr`. A column strobe falls only while the row strobe is low, and no sooner than T_RCD cycles after the row strobe fell.
- R3: `req_be[0]` selects the low lane (data bits 7:0, strobe `casl_n`) and `req_be[1]` the high lane (bits 15:8, strobe `cash_n`). Selected lanes fall in the same cycle, so both lanes always share one write mode. A write changes only the selected lanes of the stored word.
- R4: On a write, `we_n` is low, `oe_n` is high and `dq_oe` is high with the data on `dq_out` before the column strobe falls.
- R5: On a read, `oe_n` is low and `we_n` high while the column strobe is low. `rd_valid` pulses for exactly one cycle with the word sampled at the end of the column strobe. Bits of a lane that was not selected read as zero.
- R6: A request to the open row reuses it without a new row strobe fall. The column strobes stay high for at least T_CP cycles between column cycles.
- R7: A request to a different row raises the row strobe and opens the new row with a fresh fall.
- R8: The row strobe never stays low for more than T_RAS_MAX cycles. The row is closed in time both under continuous same-row hits and when no request arrives.
- R9: `ref_gnt` rises only while all strobes are high and after at least T_RP cycles of row precharge. An open row is closed when `ref_req` rises. `req_ready` stays low while `ref_req` is high. `ref_gnt` falls once `ref_req` is withdrawn.
- R10: Every column strobe low pulse lasts exactly T_CAS cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken at this clock edge when valid |
| req_row | input | ROW_W | Row of the request |
| req_col | input | COL_W | Column of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte-lane enables (bit 0 low lane, bit 1 high lane) |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 16 | Read data, unselected lanes zero |
| ref_req | input | 1 | Refresh requester wants the bus |
| ref_gnt | output | 1 | Bus yielded for refresh |
| ras_n | output | 1 | Row strobe, active low |
| casl_n | output | 1 | Low-lane column strobe, active low |
| cash_n | output | 1 | High-lane column strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dq_out | output | 16 | Data driven to the memory |
| dq_oe | output | 1 | Enable for the `dq_out` drivers |
| dq_in | input | 16 | Data returned by the memory |

## Verification
Several rules hold on every cycle, and the assertions watch them there: column strobes only inside a low row strobe, lanes falling together, early-write setup, read output enable, single-cycle read pulses, the row-strobe low-time bound and a closed row whenever the refresh grant is high. Other behaviour depends on sequences of requests, and only the bench scenarios can show it. This covers lane-merged data surviving in the memory, an unselected lane reading zero, same-row hits costing no extra row strobe while a row change costs one, the row closing during an idle spell, and requests being held off across a refresh grant.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // row closed, precharging or waiting
    ST_ASR,    // row address on the bus, row strobe next
    ST_RCD,    // row strobe low, waiting row-to-column delay
    ST_ASC,    // column address on the bus, column strobe next
    ST_CAS,    // column strobe low
    ST_OPEN,   // row open, column precharge then decide
    ST_REF     // bus yielded to refresh
  } edo_state_t;
endpackage

// File: rtl/edo_cycle_timer.sv
module edo_cycle_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  AST_TIMER_STAYS_DRAINED: assert property (@(posedge clk) disable iff (rst)
    (zero && !load) |=> zero); // R10
endmodule

// File: rtl/edo_ras_guard.sv
module edo_ras_guard #(
  parameter int T_RAS_MAX = 15000,
  parameter int SLACK     = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic ras_n,
  output logic near
);
  localparam int CW  = $clog2(T_RAS_MAX + 2);
  localparam int THR = T_RAS_MAX - SLACK;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || ras_n)       cnt <= '0;
    else if (cnt != '1)     cnt <= cnt + 1'b1;
  end

  assign near = (cnt >= CW'(THR));

  AST_RAS_LOW_BOUND: assert property (@(posedge clk) disable iff (rst)
    !ras_n |-> (cnt < CW'(T_RAS_MAX))); // R8
endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
  import edo_pkg::*;
#(
  parameter int ROW_W     = 12,
  parameter int COL_W     = 10,
  parameter int T_RCD     = 2,
  parameter int T_CAS     = 2,
  parameter int T_CP      = 1,
  parameter int T_RP      = 4,
  parameter int T_RAS_MAX = 15000
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   req_valid,
  output logic                                   req_ready,
  input  logic [ROW_W-1:0]                       req_row,
  input  logic [COL_W-1:0]                       req_col,
  input  logic                                   req_write,
  input  logic [1:0]                             req_be,
  input  logic [15:0]                            req_wdata,
  output logic                                   rd_valid,
  output logic [15:0]                            rd_data,
  input  logic                                   ref_req,
  output logic                                   ref_gnt,
  output logic                                   ras_n,
  output logic                                   casl_n,
  output logic                                   cash_n,
  output logic                                   we_n,
  output logic                                   oe_n,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic [15:0]                            dq_out,
  output logic                                   dq_oe,
  input  logic [15:0]                            dq_in
);
  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int M1     = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int M2     = (T_CP > T_RP) ? T_CP : T_RP;
  localparam int TMAX   = (M1 > M2) ? M1 : M2;
  localparam int TW     = $clog2(TMAX + 1);
  localparam int SLACK  = T_CAS + T_CP + 2;

  edo_state_t       state;
  logic [ROW_W-1:0] open_row;
  logic [COL_W-1:0] cur_col;
  logic             cur_write;
  logic [1:0]       cur_be;
  logic [15:0]      cur_wdata;
  logic [15:0]      lane_mask;

  logic          tmr_load, tmr_zero, rp_load, rp_zero, near;
  logic [TW-1:0] tmr_val;
  logic          start_ref, close_now, accept, row_hit;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_mask[g*LANE_W +: LANE_W] = {LANE_W{cur_be[g]}};
    end
  endgenerate

  assign row_hit   = (req_row == open_row);
  assign req_ready = !ref_req &&
                     (((state == ST_IDLE) && rp_zero) ||
                      ((state == ST_OPEN) && tmr_zero && !near && row_hit));
  assign accept    = req_valid && req_ready;
  assign start_ref = (state == ST_IDLE) && rp_zero && ref_req;
  assign close_now = (state == ST_OPEN) && tmr_zero &&
                     (ref_req || near || (req_valid && !row_hit));
  assign rp_load   = close_now || ((state == ST_REF) && !ref_req);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state)
      ST_ASR: begin tmr_load = 1'b1; tmr_val = TW'(T_RCD - 1); end
      ST_ASC: begin tmr_load = 1'b1; tmr_val = TW'(T_CAS - 1); end
      ST_CAS: if (tmr_zero) begin tmr_load = 1'b1; tmr_val = TW'(T_CP - 1); end
      default: ;
    endcase
  end

  edo_cycle_timer #(.W(TW)) u_step_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero));

  edo_cycle_timer #(.W(TW)) u_rp_tmr (
    .clk(clk), .rst(rst), .load(rp_load), .load_val(TW'(T_RP - 1)), .zero(rp_zero));

  edo_ras_guard #(.T_RAS_MAX(T_RAS_MAX), .SLACK(SLACK)) u_guard (
    .clk(clk), .rst(rst), .ras_n(ras_n), .near(near));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ras_n     <= 1'b1;
      casl_n    <= 1'b1;
      cash_n    <= 1'b1;
      we_n      <= 1'b1;
      oe_n      <= 1'b1;
      dq_oe     <= 1'b0;
      dq_out    <= '0;
      dram_addr <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      ref_gnt   <= 1'b0;
      open_row  <= '0;
      cur_col   <= '0;
      cur_write <= 1'b0;
      cur_be    <= '0;
      cur_wdata <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start_ref) begin
            ref_gnt <= 1'b1;
            state   <= ST_REF;
          end else if (accept) begin
            dram_addr <= ADDR_W'(req_row);
            open_row  <= req_row;
            cur_col   <= req_col;
            cur_write <= req_write;
            cur_be    <= req_be;
            cur_wdata <= req_wdata;
            state     <= ST_ASR;
          end
        end
        ST_ASR: begin
          ras_n <= 1'b0;
          state <= ST_RCD;
        end
        ST_RCD: begin
          if (tmr_zero) begin
            dram_addr <= ADDR_W'(cur_col);
            we_n      <= ~cur_write;
            oe_n      <= cur_write;
            dq_out    <= cur_wdata;
            dq_oe     <= cur_write;
            state     <= ST_ASC;
          end
        end
        ST_ASC: begin
          casl_n <= ~cur_be[0];
          cash_n <= ~cur_be[1];
          state  <= ST_CAS;
        end
        ST_CAS: begin
          if (tmr_zero) begin
            casl_n <= 1'b1;
            cash_n <= 1'b1;
            we_n   <= 1'b1;
            oe_n   <= 1'b1;
            dq_oe  <= 1'b0;
            if (!cur_write) begin
              rd_valid <= 1'b1;
              rd_data  <= dq_in & lane_mask;
            end
            state <= ST_OPEN;
          end
        end
        ST_OPEN: begin
          if (close_now) begin
            ras_n <= 1'b1;
            state <= ST_IDLE;
          end else if (accept) begin
            dram_addr <= ADDR_W'(req_col);
            cur_col   <= req_col;
            cur_write <= req_write;
            cur_be    <= req_be;
            cur_wdata <= req_wdata;
            we_n      <= ~req_write;
            oe_n      <= req_write;
            dq_out    <= req_wdata;
            dq_oe     <= req_write;
            state     <= ST_ASC;
          end
        end
        ST_REF: begin
          if (!ref_req) begin
            ref_gnt <= 1'b0;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_GNT_ROW_CLOSED: assert property (@(posedge clk) disable iff (rst)
    ref_gnt |-> (ras_n && casl_n && cash_n)); // R9
  AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (rst)
    (!casl_n || !cash_n) |-> !ras_n); // R2
  AST_LOW_LANE_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    $fell(casl_n) |-> $past(cash_n)); // R3
  AST_HIGH_LANE_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    $fell(cash_n) |-> $past(casl_n)); // R3
  AST_EARLY_WRITE_SETUP: assert property (@(posedge clk) disable iff (rst)
    ($past(casl_n && cash_n) && !(casl_n && cash_n) && !we_n)
      |-> (oe_n && dq_oe && $past(!we_n))); // R4
  AST_READ_OUTPUT_ON: assert property (@(posedge clk) disable iff (rst)
    ($past(casl_n && cash_n) && !(casl_n && cash_n) && we_n)
      |-> (!oe_n && !dq_oe)); // R5
  AST_RD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid); // R5
endmodule

// File: tb/edo_page_ctrl_test.sv
module edo_page_ctrl_test;
  localparam int ROW_W = 12, COL_W = 10;
  localparam int T_RCD = 2, T_CAS = 2, T_CP = 1, T_RP = 3, T_RAS_MAX = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic             req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [1:0]       req_be = 2'b11;
  logic [15:0]      req_wdata = '0;
  logic             rd_valid, ref_req = 1'b0, ref_gnt;
  logic [15:0]      rd_data, dq_out;
  logic [15:0]      dq_in = '0;
  logic             ras_n, casl_n, cash_n, we_n, oe_n, dq_oe;
  logic [ROW_W-1:0] dram_addr;

  edo_page_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD), .T_CAS(T_CAS),
                  .T_CP(T_CP), .T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col), .req_write(req_write), .req_be(req_be),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .ref_req(ref_req), .ref_gnt(ref_gnt), .ras_n(ras_n), .casl_n(casl_n),
    .cash_n(cash_n), .we_n(we_n), .oe_n(oe_n), .dram_addr(dram_addr),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in));

  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural memory seen through the pins, and the bench's own expectation
  logic [7:0]  dram_lo [int];
  logic [7:0]  dram_hi [int];
  logic [7:0]  ref_lo  [int];
  logic [7:0]  ref_hi  [int];
  logic [15:0] expq [$];
  logic [15:0] last_rd = '0;

  logic prev_ras = 1'b1, prev_l = 1'b1, prev_h = 1'b1, prev_gnt = 1'b0;
  int ras_high_len = 1000, ras_low_len = 0, cas_high_len = 1000, cas_low_len = 0;
  int ras_fall_cnt = 0, max_low = 0;
  int mrow = 0, mcol = 0, key = 0;
  logic [15:0] e;

  always @(negedge clk) begin
    if (rst) begin
      prev_ras = 1'b1; prev_l = 1'b1; prev_h = 1'b1; prev_gnt = 1'b0;
      ras_high_len = 1000; ras_low_len = 0; cas_high_len = 1000; cas_low_len = 0;
    end else begin
      if (prev_ras && !ras_n) begin
        check(ras_high_len >= T_RP, "R2 row precharge before open", ras_high_len, T_RP);
        ras_fall_cnt++;
        mrow = int'(dram_addr);
      end
      if ((prev_l && !casl_n) || (prev_h && !cash_n)) begin
        check(!ras_n, "R2 column strobe inside row strobe", ras_n, 0);
        check(ras_low_len >= T_RCD, "R2 row to column delay", ras_low_len, T_RCD);
        check(cas_high_len >= T_CP, "R6 column precharge", cas_high_len, T_CP);
        check((casl_n || prev_l) && (cash_n || prev_h), "R3 lanes fall together",
              {prev_l, prev_h}, 2'b11);
        if (!we_n)
          check(oe_n && dq_oe, "R4 early write setup", {oe_n, dq_oe}, 2'b11);
        else
          check(!oe_n && !dq_oe, "R5 read output enable", {oe_n, dq_oe}, 2'b00);
        mcol = int'(dram_addr[COL_W-1:0]);
        key  = (mrow << COL_W) | mcol;
        if (!we_n) begin
          if (!casl_n) dram_lo[key] = dq_out[7:0];
          if (!cash_n) dram_hi[key] = dq_out[15:8];
        end
        cas_low_len = 0;
      end
      if (casl_n && cash_n && !(prev_l && prev_h))
        check(cas_low_len == T_CAS, "R10 column strobe width", cas_low_len, T_CAS);
      if (ref_gnt && !prev_gnt)
        check(ras_n && casl_n && cash_n && ras_high_len >= T_RP,
              "R9 grant only with row closed and precharged", ras_high_len, T_RP);
      if (rd_valid) begin
        if (expq.size() == 0) check(1'b0, "R5 unexpected read pulse", 1, 0);
        else begin
          e = expq.pop_front();
          check(rd_data == e, "R5 read data", rd_data, e);
        end
        last_rd = rd_data;
      end
      // counters
      if (ras_n) begin ras_high_len++; ras_low_len = 0; end
      else begin
        ras_low_len++; ras_high_len = 0;
        if (ras_low_len > max_low) max_low = ras_low_len;
        check(ras_low_len <= T_RAS_MAX, "R8 row strobe low time", ras_low_len, T_RAS_MAX);
      end
      if (casl_n && cash_n) cas_high_len++;
      else begin cas_high_len = 0; cas_low_len++; end
      prev_ras = ras_n; prev_l = casl_n; prev_h = cash_n; prev_gnt = ref_gnt;
    end
    // memory drives read data; unselected lanes carry junk patterns
    dq_in[7:0]  = (!ras_n && !casl_n && !oe_n && we_n) ?
                  (dram_lo.exists(key) ? dram_lo[key] : 8'h00) : 8'hA5;
    dq_in[15:8] = (!ras_n && !cash_n && !oe_n && we_n) ?
                  (dram_hi.exists(key) ? dram_hi[key] : 8'h00) : 8'h5A;
  end

  task automatic do_req(input int row, input int col, input bit wr,
                        input logic [1:0] be, input logic [15:0] d);
    int k;
    logic [15:0] x;
    req_row = ROW_W'(row); req_col = COL_W'(col); req_write = wr;
    req_be = be; req_wdata = d; req_valid = 1'b1;
    forever begin
      #2;
      if (req_ready) break;
      @(negedge clk);
    end
    k = (row << COL_W) | col;
    if (wr) begin
      if (be[0]) ref_lo[k] = d[7:0];
      if (be[1]) ref_hi[k] = d[15:8];
    end else begin
      x[7:0]  = be[0] ? (ref_lo.exists(k) ? ref_lo[k] : 8'h00) : 8'h00;
      x[15:8] = be[1] ? (ref_hi.exists(k) ? ref_hi[k] : 8'h00) : 8'h00;
      expq.push_back(x);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    int t = 0;
    while (expq.size() != 0 && t < 200) begin @(negedge clk); t++; end
    check(expq.size() == 0, "R5 all reads returned", expq.size(), 0);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  int base, blocked;
  initial begin
    repeat (5) @(negedge clk);
    check({ras_n, casl_n, cash_n, we_n, oe_n} == 5'b11111 && !dq_oe && !rd_valid && !ref_gnt,
          "R1 reset state", {ras_n, casl_n, cash_n, we_n, oe_n, dq_oe, rd_valid, ref_gnt},
          8'hF8);
    rst = 1'b0;
    @(negedge clk);
    check({ras_n, casl_n, cash_n, we_n, oe_n} == 5'b11111 && !dq_oe,
          "R1 idle after reset", {ras_n, casl_n, cash_n, we_n, oe_n, dq_oe}, 6'h3E);

    // R4 R5: word write and read back
    do_req(5, 3, 1'b1, 2'b11, 16'hBEEF);
    do_req(5, 3, 1'b0, 2'b11, 16'h0);
    drain();
    check(last_rd == 16'hBEEF, "R4 word written and read", last_rd, 16'hBEEF);

    // R3: low lane write keeps high lane
    do_req(5, 3, 1'b1, 2'b01, 16'h1234);
    do_req(5, 3, 1'b0, 2'b11, 16'h0);
    drain();
    check(last_rd == 16'hBE34, "R3 low lane write only", last_rd, 16'hBE34);

    // R3 R5: high lane write, single-lane reads
    do_req(5, 4, 1'b1, 2'b11, 16'hA1B2);
    do_req(5, 4, 1'b1, 2'b10, 16'hC300);
    do_req(5, 4, 0, 2'b10, 16'h0);
    drain();
    check(last_rd == 16'hC300, "R5 unselected low lane reads zero", last_rd, 16'hC300);
    do_req(5, 4, 0, 2'b01, 16'h0);
    drain();
    check(last_rd == 16'h00B2, "R3 high lane write left low lane", last_rd, 16'h00B2);

    // R6: page hits on a fresh row
    base = ras_fall_cnt;
    for (int i = 0; i < 4; i++) do_req(7, i, 1'b1, 2'b11, 16'h7000 + 16'(i));
    check(ras_fall_cnt - base == 1, "R6 hits share one row open", ras_fall_cnt - base, 1);
    for (int i = 0; i < 4; i++) do_req(7, i, 1'b0, 2'b11, 16'h0);
    drain();

    // R7: row changes
    base = ras_fall_cnt;
    do_req(9, 1, 1'b1, 2'b11, 16'h0909);
    do_req(10, 1, 1'b1, 2'b11, 16'h1010);
    do_req(9, 1, 1'b0, 2'b11, 16'h0);
    drain();
    check(ras_fall_cnt - base == 3, "R7 each row change reopens", ras_fall_cnt - base, 3);
    check(last_rd == 16'h0909, "R7 data kept across rows", last_rd, 16'h0909);

    // R8: long same-row stream and idle open row
    base = ras_fall_cnt;
    for (int i = 0; i < 30; i++) do_req(11, i, 1'b0, 2'b11, 16'h0);
    drain();
    check(ras_fall_cnt - base >= 2, "R8 long stream forces reopen", ras_fall_cnt - base, 2);
    check(max_low <= T_RAS_MAX, "R8 longest row strobe low", max_low, T_RAS_MAX);
    do_req(12, 0, 1'b1, 2'b11, 16'h1212);
    repeat (60) @(negedge clk);
    check(ras_n == 1'b1, "R8 idle row closed", ras_n, 1);

    // R9: refresh grant
    do_req(13, 0, 1'b0, 2'b11, 16'h0);
    drain();
    check(ras_n == 1'b0, "R9 row open before refresh", ras_n, 0);
    ref_req = 1'b1;
    for (int i = 0; i < 20; i++) begin
      if (ref_gnt) break;
      @(negedge clk);
    end
    check(ref_gnt == 1'b1 && ras_n == 1'b1, "R9 refresh granted with row closed",
          {ref_gnt, ras_n}, 2'b11);
    req_row = 13; req_col = 0; req_write = 1'b0; req_be = 2'b11; req_valid = 1'b1;
    blocked = 0;
    for (int i = 0; i < 5; i++) begin
      #2;
      if (req_ready) blocked++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    check(blocked == 0, "R9 no request taken during refresh", blocked, 0);
    ref_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(ref_gnt == 1'b0, "R9 grant released", ref_gnt, 0);
    do_req(13, 0, 1'b0, 2'b11, 16'h0);
    drain();

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule